// File: doc/BRIEF.md
# Per-Pin Control Register Bank with Event Detection

This block holds one 32-bit control word for each pin of a port. The low half of each word carries the pad settings. These are a pull enable and a pull direction, the drive strength, the slew rate, the open-drain enable, the passive filter enable and a three-bit function-select field. The block presents these settings on a flat output so the pad ring can use them. The top bit of the low half is a lock. Once the lock is set, the low half stays frozen until the next reset. The high half stays writable.

The high half chooses how a pin event is reported. It picks the trigger: a rising edge, a falling edge, either edge, a low level or a high level. It also picks the target: a processor interrupt or a DMA request. A sticky flag records that the chosen event happened. Software clears the flag by writing a one to it. A DMA acknowledge clears a flag that belongs to a DMA-targeted pin.

Each pin input passes through a two-stage synchronizer. Edges are found by comparing the synchronized value with its value one cycle earlier. Register reads are combinational on the pin index. Writes take effect on the clock edge where the write strobe is high.

Top module: `pin_ctrl_bank`

## Requirements
- R1: After reset every control word reads 0, `irq` is low, every `dma_req` bit is low and `pad_cfg` is all zero.
- R2: In the low half, only bits 0,1,2,4,5,6,8,9,10 and 15 are stored; mask 0x8777. Bits 19:16 (event code) and bit 24 (flag) are the only other readable bits. Every other bit reads 0.
- R3: Once bit 15 (lock) of a pin's word is 1, writes leave bits 15:0 unchanged, the lock included, until reset. Bits 19:16 remain writable.
- R4: With event code 9, a rising edge on the pin sets flag bit 24 and drives `irq` high.
- R5: Event code 10 sets the flag on a falling edge only. Event code 11 sets it on either edge.
- R6: Event code 12 sets the flag while the pin is high. Event code 8 sets it while the pin is low. A clearing write while the level persists leaves the flag set.
- R7: Writing 1 to bit 24 clears the flag. Writing 0 to bit 24 leaves it unchanged.
- R8: Event codes 1, 2 and 3 (DMA on rising, falling or either edge) drive `dma_req[i]` from the flag and never drive `irq`. A one-cycle pulse on `dma_ack[i]` clears that flag.
- R9: Event code 0 and the unused codes (4–7, 13–15) never set the flag.
- R10: `pad_cfg[16*i+15:16*i]` equals the low half of pin i's word.
- R11: `irq` is the OR of the flags of all pins whose event code targets the interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | AW | Pin index for read and write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Control word of the addressed pin |
| pin_in | input | NUM_PINS | Asynchronous pin levels |
| dma_ack | input | NUM_PINS | Per-pin DMA acknowledge |
| dma_req | output | NUM_PINS | Per-pin DMA request |
| irq | output | 1 | Combined interrupt request |
| pad_cfg | output | 16*NUM_PINS | Low half of every pin word |

## Verification
The assertions assume the following about the inputs. `dma_ack` is pulsed only for a pin whose request is up. Each pin level is held long enough to pass the two-stage synchronizer, so an edge is seen as a single change of the synchronized value. The stimulus moves pins and strobes only on the falling clock edge. It holds each new pin level for at least four cycles before sampling the flag. It also clears leftover flags before switching a pin to a new event code, so that no flag from an earlier test is counted against a later one.

// File: rtl/pinctl_pkg.sv
package pinctl_pkg;

    localparam int WORD_W   = 32;
    localparam int HALF_W   = 16;
    localparam int LOCK_BIT = 15;
    localparam int EVT_LO   = 16;
    localparam int EVT_W    = 4;
    localparam int FLAG_BIT = 24;

    // stored low-half bits: pull sel/en, slew, filter, open drain, drive, mux[2:0], lock
    localparam logic [HALF_W-1:0] LOW_KEEP = 16'h8777;

    typedef enum logic [EVT_W-1:0] {
        EV_OFF      = 4'd0,
        EV_DMA_RISE = 4'd1,
        EV_DMA_FALL = 4'd2,
        EV_DMA_BOTH = 4'd3,
        EV_IRQ_LOW  = 4'd8,
        EV_IRQ_RISE = 4'd9,
        EV_IRQ_FALL = 4'd10,
        EV_IRQ_BOTH = 4'd11,
        EV_IRQ_HIGH = 4'd12
    } evt_code_e;

    function automatic logic code_is_dma(input logic [EVT_W-1:0] c);
        return (c == EV_DMA_RISE) || (c == EV_DMA_FALL) || (c == EV_DMA_BOTH);
    endfunction

    function automatic logic code_is_irq(input logic [EVT_W-1:0] c);
        return (c >= EV_IRQ_LOW) && (c <= EV_IRQ_HIGH);
    endfunction

endpackage

// File: rtl/pin_evt_det.sv
module pin_evt_det
    import pinctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pin_async,
    input  logic [EVT_W-1:0] code,
    output logic             hit
);

    typedef struct packed {
        logic meta;
        logic sync;
        logic prev;
    } det_t;

    det_t s_d, s_q;
    logic rise, fall;

    always_comb begin
        s_d      = s_q;
        s_d.meta = pin_async;
        s_d.sync = s_q.meta;
        s_d.prev = s_q.sync;

        rise = s_q.sync & ~s_q.prev;
        fall = ~s_q.sync & s_q.prev;

        unique case (code)
            EV_DMA_RISE, EV_IRQ_RISE: hit = rise;
            EV_DMA_FALL, EV_IRQ_FALL: hit = fall;
            EV_DMA_BOTH, EV_IRQ_BOTH: hit = rise | fall;
            EV_IRQ_LOW:               hit = ~s_q.sync;
            EV_IRQ_HIGH:              hit = s_q.sync;
            default:                  hit = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

endmodule

// File: rtl/pin_ctl_reg.sv
module pin_ctl_reg
    import pinctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [HALF_W-1:0] wr_low,
    input  logic [EVT_W-1:0]  wr_code,
    input  logic              wr_clr,
    input  logic              hit,
    input  logic              dma_ack,
    output logic [WORD_W-1:0] rdata,
    output logic [EVT_W-1:0]  code,
    output logic [HALF_W-1:0] pad,
    output logic              irq_src,
    output logic              dma_req
);

    typedef struct packed {
        logic [HALF_W-1:0] low;
        logic [EVT_W-1:0]  code;
        logic              flag;
    } word_t;

    word_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            if (!r_q.low[LOCK_BIT]) r_d.low = wr_low & LOW_KEEP;
            r_d.code = wr_code;
            if (wr_clr) r_d.flag = 1'b0;
        end
        if (dma_ack && code_is_dma(r_q.code)) r_d.flag = 1'b0;
        if (hit) r_d.flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        rdata                            = '0;
        rdata[HALF_W-1:0]                = r_q.low;
        rdata[EVT_LO+EVT_W-1:EVT_LO]     = r_q.code;
        rdata[FLAG_BIT]                  = r_q.flag;
        code    = r_q.code;
        pad     = r_q.low;
        irq_src = r_q.flag & code_is_irq(r_q.code);
        dma_req = r_q.flag & code_is_dma(r_q.code);
    end

    // R3: a locked low half does not move
    a_r3_lock_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.low[LOCK_BIT] |=> $stable(r_q.low));

    // R4: a detected event is recorded on the next edge
    a_r4_hit_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> r_q.flag);

    // R7: a write-one-to-clear without a new event empties the flag
    a_r7_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_clr && !hit) |=> !r_q.flag);

    // R8: acknowledge on a DMA pin clears its flag
    a_r8_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_ack && code_is_dma(r_q.code) && !hit) |=> !dma_req);

    // R9: a disabled or unused code never raises a clear flag
    a_r9_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!code_is_dma(r_q.code) && !code_is_irq(r_q.code) && !r_q.flag) |=> !r_q.flag);

endmodule

// File: rtl/pin_ctrl_bank.sv
module pin_ctrl_bank
    import pinctl_pkg::*;
#(
    parameter int NUM_PINS = 4,
    localparam int AW = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       bus_wr,
    input  logic [AW-1:0]              bus_addr,
    input  logic [WORD_W-1:0]          bus_wdata,
    output logic [WORD_W-1:0]          bus_rdata,
    input  logic [NUM_PINS-1:0]        pin_in,
    input  logic [NUM_PINS-1:0]        dma_ack,
    output logic [NUM_PINS-1:0]        dma_req,
    output logic                       irq,
    output logic [HALF_W*NUM_PINS-1:0] pad_cfg
);

    logic [WORD_W-1:0] rd_arr [NUM_PINS];
    logic [NUM_PINS-1:0] irq_vec;
    logic unused_wbits;

    assign unused_wbits = ^{bus_wdata[WORD_W-1:FLAG_BIT+1], bus_wdata[FLAG_BIT-1:EVT_LO+EVT_W]};

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        logic [EVT_W-1:0] code_i;
        logic             hit_i;
        logic             sel_i;

        assign sel_i = bus_wr && (bus_addr == AW'(i));

        pin_evt_det u_det (
            .clk       (clk),
            .rst_n     (rst_n),
            .pin_async (pin_in[i]),
            .code      (code_i),
            .hit       (hit_i)
        );

        pin_ctl_reg u_reg (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (sel_i),
            .wr_low  (bus_wdata[HALF_W-1:0]),
            .wr_code (bus_wdata[EVT_LO+EVT_W-1:EVT_LO]),
            .wr_clr  (bus_wdata[FLAG_BIT]),
            .hit     (hit_i),
            .dma_ack (dma_ack[i]),
            .rdata   (rd_arr[i]),
            .code    (code_i),
            .pad     (pad_cfg[HALF_W*i +: HALF_W]),
            .irq_src (irq_vec[i]),
            .dma_req (dma_req[i])
        );
    end

    assign bus_rdata = rd_arr[bus_addr];
    assign irq       = |irq_vec;

    // R8: DMA-routed flags never reach the interrupt line
    a_r8_irq_dma_apart: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_vec & dma_req) == '0);

endmodule

// File: tb/tb_pin_ctrl_bank.sv
module tb_pin_ctrl_bank;

    localparam int CLK_PERIOD = 10;
    localparam int N  = 4;
    localparam int AW = 2;

    logic clk = 0;
    logic rst_n = 0;
    logic bus_wr = 0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [N-1:0] pin_in = '0;
    logic [N-1:0] dma_ack = '0;
    logic [N-1:0] dma_req;
    logic irq;
    logic [16*N-1:0] pad_cfg;

    int total = 0;
    int bad = 0;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t sb_q[$];
    event  mon_ev;

    always #(CLK_PERIOD/2) clk = ~clk;

    pin_ctrl_bank #(.NUM_PINS(N)) dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .dma_ack(dma_ack), .dma_req(dma_req), .irq(irq), .pad_cfg(pad_cfg)
    );

    // monitor: pops expected read items and compares
    initial begin
        forever begin
            @(mon_ev);
            if (sb_q.size() != 0) begin
                item_t it;
                it = sb_q.pop_front();
                total++;
                if (bus_rdata !== it.exp) begin
                    bad++;
                    $display("FAIL %s: rdata=%h expected=%h", it.tag, bus_rdata, it.exp);
                end
            end
        end
    end

    task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = AW'(a);
        bus_wdata = d;
        bus_wr    = 1;
        @(negedge clk);
        bus_wr    = 0;
    endtask

    task automatic rd(input int a, input logic [31:0] e, input string tag);
        item_t it;
        @(negedge clk);
        bus_addr = AW'(a);
        #1;
        it.exp = e;
        it.tag = tag;
        sb_q.push_back(it);
        -> mon_ev;
        #1;
    endtask

    task automatic pin(input int p, input logic v);
        @(negedge clk);
        pin_in[p] = v;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1 reset state
        for (int i = 0; i < N; i++) rd(i, 32'h0, "R1 reset word");
        chk(irq, 0, "R1 irq");
        chk(dma_req, 0, "R1 dma_req");
        chk(pad_cfg, 0, "R1 pad_cfg");

        // R2 storage mask
        wr(0, 32'h0000_7FFF); rd(0, 32'h0000_0777, "R2 low mask");
        wr(0, 32'hFEF0_8888); rd(0, 32'h0000_8000, "R2 unused bits");
        rst_n = 0; @(negedge clk); rst_n = 1;
        wr(0, 32'h000F_0000); rd(0, 32'h000F_0000, "R2 code field");

        // R10 pad output
        wr(2, 32'h0000_0523);
        chk(pad_cfg[47:32], 16'h0523, "R10 pad pin2");

        // R3 lock
        wr(3, 32'h0000_8155); rd(3, 32'h0000_8155, "R3 lock write");
        wr(3, 32'h000C_0002); rd(3, 32'h000C_8155, "R3 locked low, code writable");
        wr(3, 32'h0000_0000); rd(3, 32'h0000_8155, "R3 lock not clearable");

        // R4 rising edge interrupt
        wr(0, 32'h0009_0000);
        pin(0, 1);
        rd(0, 32'h0109_0000, "R4 rise flag");
        chk(irq, 1, "R4 irq");
        wr(0, 32'h0109_0000); rd(0, 32'h0009_0000, "R7 w1c");
        chk(irq, 0, "R7 irq low");

        // R5 falling and both
        wr(0, 32'h000A_0000);
        pin(0, 0); rd(0, 32'h010A_0000, "R5 fall flag");
        wr(0, 32'h010A_0000);
        pin(0, 1); rd(0, 32'h000A_0000, "R5 rise ignored by fall code");
        wr(0, 32'h000B_0000);
        pin(0, 0); rd(0, 32'h010B_0000, "R5 both fall");
        wr(0, 32'h010B_0000);
        pin(0, 1); rd(0, 32'h010B_0000, "R5 both rise");
        wr(0, 32'h000B_0000); rd(0, 32'h010B_0000, "R7 write zero keeps flag");
        wr(0, 32'h010B_0000); rd(0, 32'h000B_0000, "R7 cleared");

        // R6 levels
        wr(1, 32'h000C_0000);
        pin(1, 1); rd(1, 32'h010C_0000, "R6 high level");
        wr(1, 32'h010C_0000); rd(1, 32'h010C_0000, "R6 level re-sets");
        pin(1, 0);
        wr(1, 32'h010C_0000); rd(1, 32'h000C_0000, "R6 level gone");
        wr(1, 32'h0008_0000);
        repeat (2) @(negedge clk);
        rd(1, 32'h0108_0000, "R6 low level");
        pin(1, 1);
        wr(1, 32'h0108_0000); rd(1, 32'h0008_0000, "R6 low gone");
        wr(1, 32'h0100_0000);

        // R11 interrupt OR
        wr(2, 32'h0009_0523);
        pin(2, 1);
        chk(irq, 1, "R11 single source");
        wr(2, 32'h010A_0523);
        wr(0, 32'h000A_0000);
        @(negedge clk); pin_in[0] = 0; pin_in[2] = 0;
        repeat (4) @(negedge clk);
        wr(0, 32'h010A_0000);
        chk(irq, 1, "R11 other source holds");
        wr(2, 32'h010A_0523);
        chk(irq, 0, "R11 all clear");
        chk(pad_cfg[47:32], 16'h0523, "R10 pad kept");

        // R8 DMA
        wr(1, 32'h0002_0000);
        pin(1, 0);
        chk(dma_req, 4'b0010, "R8 dma fall");
        chk(irq, 0, "R8 no irq");
        @(negedge clk); dma_ack[1] = 1;
        @(negedge clk); dma_ack[1] = 0;
        chk(dma_req, 4'b0000, "R8 ack clears");
        rd(1, 32'h0002_0000, "R8 flag cleared");
        wr(1, 32'h0003_0000);
        pin(1, 1);
        chk(dma_req, 4'b0010, "R8 dma both");
        wr(1, 32'h0100_0000);

        // R9 disabled and unused codes
        pin(1, 0); pin(1, 1);
        rd(1, 32'h0000_0000, "R9 code 0");
        wr(1, 32'h0005_0000);
        pin(1, 0); pin(1, 1);
        rd(1, 32'h0005_0000, "R9 code 5");

        // R3 lock ends at reset
        @(negedge clk); rst_n = 0;
        @(negedge clk); rst_n = 1;
        rd(3, 32'h0, "R3 reset releases lock");
        wr(3, 32'h0000_0011); rd(3, 32'h0000_0011, "R3 writable after reset");

        repeat (2) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule